// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control core of a 14-bit sampling converter. A rising edge on the convert-start input puts the sampler into hold and starts a conversion. At that same edge the block samples the clock-select pin to choose the conversion clock. A low pin selects an internal tick, generated every `INT_DIV` system clocks. A high pin selects falling edges taken from that same pin, which then carries the external clock.

The block counts 16 conversion clocks. On the 15th it loads the already-digitized two's-complement result into an output register. The level of convert-start at that moment sets the status behaviour: a busy level, or a short end-of-conversion pulse.

All asynchronous inputs pass through two-flop synchronizers into the system clock domain. The result register can be read back through a chip-select and read strobe pair, both active low.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `status_out`, `hold_out`, `data_oe` and `data_out` are all zero.
- R2: A rising edge of the synchronized `start_in` while idle starts a conversion: `hold_out` and `status_out` go high on the same clock.
- R3: A conversion lasts 16 conversion clocks, and `hold_out` returns low after the 16th.
- R4: The internal conversion clock ticks once every `INT_DIV` system clocks. `status_out` therefore stays high for exactly `INT_DIV`*15 clocks after `hold_out` rises, before the load.
- R5: On the 15th conversion clock, `result_in` is copied unchanged into the output register, once per conversion. This includes the extreme codes 0x1FFF (most positive) and 0x2000 (most negative). The register holds its value until the next load.
- R6: If `start_in` is high at the load, the status works in end-of-conversion mode: `status_out` goes low for exactly one clock after the load, then returns high. If `start_in` is low at the load, the status works in busy mode: `status_out` falls at the load and stays low.
- R7: If the synchronized `clk_sel` is high at the start edge, the conversion clock is taken from falling edges of `clk_sel`. The 15th such edge loads the result, and no load happens after only 14.
- R8: In external mode, a falling edge of `clk_sel` seen within `BLANK` system clocks of the start is not counted.
- R9: A `start_in` rising edge during a conversion is ignored. It neither shortens the conversion nor starts a new one.
- R10: In internal mode, toggling `clk_sel` during the conversion has no effect on its timing.
- R11: While the synchronized `cs_n` and `rd_n` are both low, `data_oe` is 1 and `data_out` shows the register. Otherwise `data_oe` is 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_in | input | 1 | Convert-start, asynchronous |
| clk_sel | input | 1 | Clock-select level at start; external conversion clock afterwards |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| result_in | input | 14 | Digitized sample, two's complement |
| hold_out | output | 1 | High while the sample is held and converting |
| status_out | output | 1 | Busy level or end-of-conversion pulse |
| data_oe | output | 1 | High while the read port drives data |
| data_out | output | 14 | Read data, zero when not selected |

## Verification
The assertions assume three things about the external clock. It is slow enough that the 16th conversion clock comes after the end-of-conversion pulse. Each conversion clock spans at least one system clock. A read never overlaps the load cycle while `status_out` is high.

The stimulus meets these assumptions. Each external clock level is held for four system clocks, and reads are issued only after `hold_out` has fallen. `start_in` is held for several clocks, so every edge survives the synchronizer.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DW      = 14,
  parameter int NCLK    = 16,
  parameter int LOAD_AT = 15,
  parameter int INT_DIV = 4,
  parameter int BLANK   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_in,
  input  logic          clk_sel,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic [DW-1:0] result_in,
  output logic          hold_out,
  output logic          status_out,
  output logic          data_oe,
  output logic [DW-1:0] data_out
);
  localparam int CW  = $clog2(NCLK + 1);
  localparam int DVW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int BW  = $clog2(BLANK + 1);

  logic [2:0]     st_q, ck_q;
  logic [1:0]     cs_q, rd_q;
  logic           conv, ext, stat, eoc_pend;
  logic [CW-1:0]  cnt;
  logic [DVW-1:0] div;
  logic [BW-1:0]  blank;
  logic [DW-1:0]  res_q;

  wire start_rise = st_q[1] & ~st_q[2];
  wire ck_fall    = ck_q[2] & ~ck_q[1];
  wire tick       = ext ? (ck_fall && blank == '0) : (div == DVW'(INT_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      ck_q <= '0;
      cs_q <= '1;
      rd_q <= '1;
    end else begin
      st_q <= {st_q[1:0], start_in};
      ck_q <= {ck_q[1:0], clk_sel};
      cs_q <= {cs_q[0], cs_n};
      rd_q <= {rd_q[0], rd_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv     <= 1'b0;
      ext      <= 1'b0;
      stat     <= 1'b0;
      eoc_pend <= 1'b0;
      cnt      <= '0;
      div      <= '0;
      blank    <= '0;
      res_q    <= '0;
    end else begin
      eoc_pend <= 1'b0;
      if (eoc_pend) stat <= 1'b1;
      if (!conv) begin
        if (start_rise) begin
          conv  <= 1'b1;
          ext   <= ck_q[1];
          cnt   <= '0;
          div   <= '0;
          blank <= BW'(BLANK);
          stat  <= 1'b1;
        end
      end else begin
        if (blank != '0) blank <= blank - 1'b1;
        if (!ext) div <= (div == DVW'(INT_DIV - 1)) ? '0 : div + 1'b1;
        if (tick) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(LOAD_AT - 1)) begin
            res_q    <= result_in;
            stat     <= 1'b0;
            eoc_pend <= st_q[1];
          end
          if (cnt == CW'(NCLK - 1)) conv <= 1'b0;
        end
      end
    end
  end

  assign hold_out   = conv;
  assign status_out = stat;
  assign data_oe    = ~cs_q[1] & ~rd_q[1];
  assign data_out   = data_oe ? res_q : '0;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_out,
  input logic          status_out,
  input logic          data_oe,
  input logic [DW-1:0] data_out
);
  logic [7:0] hcnt;
  logic [1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      hcnt <= !hold_out ? 8'd0 : (hcnt == 8'hFF ? hcnt : hcnt + 8'd1);
      if (!hold_out) fcnt <= '0;
      else if ($fell(status_out) && fcnt != 2'd3) fcnt <= fcnt + 2'd1;
    end
  end

  assert_start_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_out) |-> status_out);

  assert_hold_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_out) |-> hcnt >= 8'd16);

  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= 2'd1);

  assert_status_rise_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_out) |-> hold_out);

  assert_read_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && status_out) |-> $stable(data_out));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_out(hold_out), .status_out(status_out),
  .data_oe(data_oe), .data_out(data_out)
);

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INT_DIV = 4;

  typedef struct { int lat; bit eoc; } exp_t;

  logic clk = 0, rst_n = 0, start_in = 0, clk_sel = 0, cs_n = 1, rd_n = 1;
  logic [13:0] result_in = '0;
  logic hold_out, status_out, data_oe;
  logic [13:0] data_out;
  int n_run = 0, n_fail = 0;
  exp_t sb[$];

  adc_conv_seq #(.INT_DIV(INT_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .clk_sel(clk_sel),
    .cs_n(cs_n), .rd_n(rd_n), .result_in(result_in), .hold_out(hold_out),
    .status_out(status_out), .data_oe(data_oe), .data_out(data_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_check(input logic [13:0] val);
    cs_n = 0; rd_n = 0; waitn(4);
    check("R11 oe", data_oe, 1);
    check("R5 data", data_out, val);
    rd_n = 1; waitn(4);
    check("R11 deselect oe", data_oe, 0);
    check("R11 deselect data", data_out, 0);
    cs_n = 1;
  endtask

  task automatic run_int(input logic [13:0] val, input bit eoc, input bit poke, input bit restart);
    result_in = val; clk_sel = 0;
    sb.push_back('{lat: INT_DIV*15, eoc: eoc});
    start_in = 1; waitn(3);
    if (!eoc) start_in = 0;
    waitn(15);
    if (poke) begin clk_sel = 1; waitn(6); clk_sel = 0; waitn(3); clk_sel = 1; end
    if (restart) begin start_in = 1; waitn(4); start_in = 0; end
    @(negedge hold_out); @(negedge clk);
    start_in = 0; clk_sel = 0;
    result_in = ~val; waitn(4);
    read_check(val);
    if (restart) begin
      waitn(60);
      check("R9 no second conversion", hold_out, 0);
    end
  endtask

  task automatic ext_fall;
    clk_sel = 0; waitn(4); clk_sel = 1; waitn(4);
  endtask

  task automatic run_ext(input logic [13:0] val);
    result_in = val; clk_sel = 1; waitn(5);
    sb.push_back('{lat: 0, eoc: 0});
    start_in = 1;
    @(posedge hold_out); @(negedge clk);
    clk_sel = 0; waitn(2); clk_sel = 1;
    start_in = 0; waitn(20);
    for (int i = 0; i < 14; i++) ext_fall();
    check("R8 no load after early edge plus 14", status_out, 1);
    check("R7 still converting", hold_out, 1);
    ext_fall();
    check("R7 loaded on 15th edge", status_out, 0);
    ext_fall(); waitn(2);
    check("R3 hold ends after 16th", hold_out, 0);
    clk_sel = 0; result_in = ~val; waitn(4);
    read_check(val);
  endtask

  initial begin : monitor
    forever begin
      int cyc;
      exp_t e;
      @(posedge hold_out);
      cyc = 0;
      forever begin
        @(negedge clk);
        if (!status_out) break;
        cyc++;
      end
      e = sb.pop_front();
      if (e.lat != 0) check("R4/R10 load latency", cyc, e.lat);
      @(negedge clk);
      check("R6 status after load", status_out, e.eoc);
      check("R3 hold still high after load", hold_out, 1);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : driver
    waitn(3);
    check("R1 status", status_out, 0);
    check("R1 hold", hold_out, 0);
    check("R1 oe", data_oe, 0);
    check("R1 data", data_out, 0);
    rst_n = 1; waitn(3);
    run_int(14'h1FFF, 1'b0, 1'b0, 1'b0);
    run_int(14'h2000, 1'b1, 1'b0, 1'b0);
    run_int(14'h0A5C, 1'b0, 1'b1, 1'b0);
    run_int(14'h3FFF, 1'b0, 1'b0, 1'b1);
    run_ext(14'h1234);
    run_int(14'h0001, 1'b1, 1'b1, 1'b0);
    waitn(10);
    check("R2 idle after runs", hold_out, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule